// File: doc/BRIEF.md
# Multiphase Waveform Sample Capture

This block taps the per-phase sample streams of a three-phase measurement datapath and copies one of them into a 24-bit sample register. A control write picks the stream (current or voltage), the phase (one of three) and a power-of-two decimation factor. Each captured value becomes visible in the sample register together with a sticky ready flag. When the ready mask is set, an active-low interrupt line tells a host that a fresh sample is waiting.

Current samples arrive as 24-bit two's complement words. Voltage samples are 16 bits wide and are sign-extended to fill the common register. A host reads the sample register and then performs a status read, which clears the ready flag and releases the interrupt. The capture path only observes the streams, so the energy processing that shares them is never disturbed.

Top module: `wcap_top`

## Requirements
- R1: After reset the sample register is 0, the ready flag is 0 and `irq_n` is 1. The configuration defaults to source 000, phase 00 and rate 00, so the first strobe after reset captures phase 0 of the current stream.
- R2: Source code 000 selects the current stream and 001 selects the voltage stream. Any other source code captures nothing.
- R3: Phase codes 00, 01 and 10 select phase 0, 1 and 2. Phase p occupies bits [24p+23:24p] of `cur_bus` and bits [16p+15:16p] of `volt_bus`. Phase code 11 captures nothing.
- R4: With rate code k, only every 2^k-th strobe is captured: the strobes numbered 0, 2^k, 2·2^k and so on, counted from the last configuration write (or from reset).
- R5: A voltage sample v is stored as 24 bits, with bits [23:16] all equal to v[15] and bits [15:0] equal to v.
- R6: A captured sample appears in `wave_reg`, and `rdy_flag` rises, at the clock edge that samples the strobe.
- R7: A configuration write restarts the decimation count. A strobe in the same cycle as the write is neither captured nor counted, so the next strobe is captured.
- R8: `rdy_flag` is set by a capture whatever the mask. `irq_n` is 0 exactly when `rdy_flag` is 1 and `rdy_mask` is 1.
- R9: A status read (`stat_rd`) clears `rdy_flag` at the next edge. If a capture happens in the same cycle, the flag stays 1.
- R10: `wave_reg` holds its value in every cycle without a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Base-rate strobe, qualifies both sample buses |
| cur_bus | input | 72 | Three 24-bit current samples, phase 0 in the low bits |
| volt_bus | input | 48 | Three 16-bit voltage samples, phase 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 3 | Source code (000 current, 001 voltage) |
| cfg_phase | input | 2 | Phase code (11 reserved) |
| cfg_rate | input | 2 | Decimation code k, output rate = base / 2^k |
| rdy_mask | input | 1 | Interrupt enable for the ready flag |
| stat_rd | input | 1 | Status read strobe, clears the ready flag |
| wave_reg | output | 24 | Captured sample register |
| rdy_flag | output | 1 | Sticky sample-ready status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A capture and a status read can land in the same cycle. The flag must then stay set, so that the new sample is not lost. The bench provokes this on purpose by asserting `stat_rd` together with a strobe that lands on count 0, and it also lets the random phase overlap the two freely. It judges the result against a bench model in which a capture takes priority over the clear. A configuration write that coincides with a strobe is the second collision. It is forced in a directed case, and the bench expects that strobe to be dropped and the next one to be captured.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  typedef enum logic [2:0] {
    SRC_CUR  = 3'b000,
    SRC_VOLT = 3'b001
  } wcap_src_e;

  function automatic logic src_known(input logic [2:0] s);
    return (s == SRC_CUR) || (s == SRC_VOLT);
  endfunction

  // wrap mask of the decimation counter for rate code k: 2^k - 1
  function automatic logic [7:0] rate_wrap(input logic [3:0] k);
    return 8'((9'd1 << k) - 9'd1);
  endfunction
endpackage

// File: rtl/wcap_cfg.sv
module wcap_cfg #(
  parameter int PH_W   = 2,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        src_in,
  input  logic [PH_W-1:0]   ph_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic [2:0]        src_q,
  output logic [PH_W-1:0]   ph_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              restart
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 3'b000;
      ph_q   <= '0;
      rate_q <= '0;
    end else if (we) begin
      src_q  <= src_in;
      ph_q   <= ph_in;
      rate_q <= rate_in;
    end
  end

  assign restart = we;
endmodule

// File: rtl/wcap_decim.sv
module wcap_decim #(
  parameter int RATE_W = 2,
  localparam int CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              vld,
  input  logic [RATE_W-1:0] rate_q,
  input  logic              sel_ok,
  output logic              fire,
  output logic [CNT_W-1:0]  cnt
);
  import wcap_pkg::*;

  logic [CNT_W-1:0] wrap;
  assign wrap = CNT_W'(rate_wrap(4'(rate_q)));

  assign fire = vld && !restart && (cnt == '0) && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (vld)     cnt <= (cnt + CNT_W'(1)) & wrap;
  end

  // R4: the count never leaves the window of the selected rate
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt & ~wrap) == '0);
  // R7: a configuration write restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  // R7: no capture in the cycle of a configuration write
  a_r7_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !fire);
endmodule

// File: rtl/wcap_mux.sv
module wcap_mux #(
  parameter int NPH    = 3,
  parameter int CUR_W  = 24,
  parameter int VOLT_W = 16,
  parameter int OUT_W  = 24,
  parameter int PH_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [2:0]           src_q,
  input  logic [PH_W-1:0]      ph_q,
  input  logic [NPH*CUR_W-1:0] cur_bus,
  input  logic [NPH*VOLT_W-1:0] volt_bus,
  output logic [OUT_W-1:0]     wave
);
  import wcap_pkg::*;

  logic [OUT_W-1:0] cur_w  [NPH];
  logic [OUT_W-1:0] volt_w [NPH];
  logic [OUT_W-1:0] pick;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [VOLT_W-1:0] v;
    assign v         = volt_bus[p*VOLT_W +: VOLT_W];
    assign cur_w[p]  = OUT_W'(cur_bus[p*CUR_W +: CUR_W]);
    assign volt_w[p] = {{(OUT_W-VOLT_W){v[VOLT_W-1]}}, v};
  end

  always_comb begin
    pick = '0;
    for (int p = 0; p < NPH; p++) begin
      if (int'(ph_q) == p) pick = (src_q == SRC_VOLT) ? volt_w[p] : cur_w[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wave <= '0;
    else if (fire) wave <= pick;
  end

  // R5: a voltage capture leaves a pure sign extension in the upper bits
  a_r5_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_q == SRC_VOLT) |=>
      ((&wave[OUT_W-1:VOLT_W-1]) || !(|wave[OUT_W-1:VOLT_W-1])));
  // R10: no capture, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(wave));
endmodule

// File: rtl/wcap_stat.sv
module wcap_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic rd,
  input  logic mask,
  output logic rdy,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdy <= 1'b0;
    else if (fire) rdy <= 1'b1;
    else if (rd)   rdy <= 1'b0;
  end

  assign irq_n = !(rdy && mask);

  // R6: a capture always leaves the flag set
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rdy);
  // R9: a read without a capture clears the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !fire) |=> !rdy);
  // R8: the flag only rises through a capture
  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(fire));
endmodule

// File: rtl/wcap_top.sv
module wcap_top #(
  parameter int NPH    = 3,
  parameter int CUR_W  = 24,
  parameter int VOLT_W = 16,
  parameter int OUT_W  = 24,
  parameter int PH_W   = 2,
  parameter int RATE_W = 2,
  localparam int CNT_W = (1 << RATE_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic [NPH*CUR_W-1:0]  cur_bus,
  input  logic [NPH*VOLT_W-1:0] volt_bus,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_src,
  input  logic [PH_W-1:0]       cfg_phase,
  input  logic [RATE_W-1:0]     cfg_rate,
  input  logic                  rdy_mask,
  input  logic                  stat_rd,
  output logic [OUT_W-1:0]      wave_reg,
  output logic                  rdy_flag,
  output logic                  irq_n
);
  import wcap_pkg::*;

  logic [2:0]        src_q;
  logic [PH_W-1:0]   ph_q;
  logic [RATE_W-1:0] rate_q;
  logic              restart;
  logic              sel_ok;
  logic              fire;
  logic [CNT_W-1:0]  cnt;

  assign sel_ok = src_known(src_q) && (int'(ph_q) < NPH);

  wcap_cfg #(.PH_W(PH_W), .RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .src_in(cfg_src), .ph_in(cfg_phase), .rate_in(cfg_rate),
    .src_q(src_q), .ph_q(ph_q), .rate_q(rate_q), .restart(restart)
  );

  wcap_decim #(.RATE_W(RATE_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .restart(restart), .vld(smp_vld),
    .rate_q(rate_q), .sel_ok(sel_ok), .fire(fire), .cnt(cnt)
  );

  wcap_mux #(.NPH(NPH), .CUR_W(CUR_W), .VOLT_W(VOLT_W), .OUT_W(OUT_W), .PH_W(PH_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .fire(fire), .src_q(src_q), .ph_q(ph_q),
    .cur_bus(cur_bus), .volt_bus(volt_bus), .wave(wave_reg)
  );

  wcap_stat u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rd(stat_rd),
    .mask(rdy_mask), .rdy(rdy_flag), .irq_n(irq_n)
  );

  // R3: the reserved phase code never captures
  a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ph_q) >= NPH) |-> !fire);
  // R2: unknown source codes never capture
  a_r2_src: assert property (@(posedge clk) disable iff (!rst_n)
    !src_known(src_q) |-> !fire);
endmodule

// File: tb/sim_wcap_top.sv
module sim_wcap_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_vld = 0;
  logic [71:0] cur_bus = '0;
  logic [47:0] volt_bus = '0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_src = 0;
  logic [1:0]  cfg_phase = 0;
  logic [1:0]  cfg_rate = 0;
  logic        rdy_mask = 0;
  logic        stat_rd = 0;
  logic [23:0] wave_reg;
  logic        rdy_flag;
  logic        irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [2:0]  m_src = 0;
  logic [1:0]  m_ph = 0, m_rate = 0;
  int          m_cnt = 0;
  logic [23:0] m_wave = 0;
  logic        m_rdy = 0;
  bit          m_cap = 0;

  wcap_top u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_pick(logic [2:0] s, logic [1:0] p);
    logic [15:0] v;
    if (s == 3'b000) return cur_bus[p*24 +: 24];
    v = volt_bus[p*16 +: 16];
    return 24'($signed(v));
  endfunction

  task automatic tick();
    @(posedge clk);
    m_cap = 0;
    if (cfg_we) begin
      m_src = cfg_src; m_ph = cfg_phase; m_rate = cfg_rate; m_cnt = 0;
    end else if (smp_vld) begin
      m_cap = (m_cnt == 0) && (m_src <= 3'b001) && (m_ph != 2'b11);
      if (m_cap) m_wave = exp_pick(m_src, m_ph);
      m_cnt = (m_cnt + 1) % (1 << m_rate);
    end
    if (m_cap) m_rdy = 1;
    else if (stat_rd) m_rdy = 0;
    #2;
    chk(m_cap ? "R6 capture value" : "R10 hold value", 32'(wave_reg), 32'(m_wave));
    chk("R9 ready flag", 32'(rdy_flag), 32'(m_rdy));
    chk("R8 irq", 32'(irq_n), 32'(!(m_rdy && rdy_mask)));
    @(negedge clk);
    smp_vld = 0; stat_rd = 0; cfg_we = 0;
  endtask

  task automatic cfg(logic [2:0] s, logic [1:0] p, logic [1:0] r);
    cfg_we = 1; cfg_src = s; cfg_phase = p; cfg_rate = r;
    tick();
  endtask

  task automatic strobe();
    cur_bus  = {$urandom, $urandom, $urandom};
    volt_bus = {$urandom, $urandom};
    smp_vld = 1;
    tick();
  endtask

  task automatic clear();
    stat_rd = 1;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int caps;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset wave", 32'(wave_reg), 0);
    chk("R1 reset ready", 32'(rdy_flag), 0);
    chk("R1 reset irq", 32'(irq_n), 1);
    rdy_mask = 1;
    strobe();
    chk("R1 default current phase0", 32'(wave_reg), 32'(cur_bus[23:0]));
    chk("R8 irq low when masked-in", 32'(irq_n), 0);
    clear();

    // R5 voltage sign extension on phase 1
    cfg(3'b001, 2'b01, 2'b00);
    volt_bus = {16'h0, 16'h8001, 16'h0}; smp_vld = 1; tick();
    chk("R5 negative voltage", 32'(wave_reg), 32'h00FF8001);
    volt_bus = {16'h0, 16'h1234, 16'h0}; smp_vld = 1; tick();
    chk("R5 positive voltage", 32'(wave_reg), 32'h00001234);
    clear();

    // R2 unknown source code
    cfg(3'b010, 2'b00, 2'b00);
    repeat (3) strobe();
    chk("R2 unknown source no capture", 32'(rdy_flag), 0);

    // R3 reserved phase, then phase 2
    cfg(3'b000, 2'b11, 2'b00);
    repeat (3) strobe();
    chk("R3 reserved phase no capture", 32'(rdy_flag), 0);
    cfg(3'b000, 2'b10, 2'b00);
    strobe();
    chk("R3 phase 2 slice", 32'(wave_reg), 32'(cur_bus[71:48]));
    clear();

    // R4 decimation by 8 and by 2
    cfg(3'b000, 2'b00, 2'b11);
    caps = 0;
    for (int i = 0; i < 16; i++) begin
      strobe();
      if (rdy_flag) caps++;
      clear();
    end
    chk("R4 rate 3 count", 32'(caps), 2);
    cfg(3'b000, 2'b00, 2'b01);
    caps = 0;
    for (int i = 0; i < 8; i++) begin
      strobe();
      if (rdy_flag) caps++;
      clear();
    end
    chk("R4 rate 1 count", 32'(caps), 4);

    // R7 restart: write collides with a strobe
    cfg(3'b000, 2'b01, 2'b10);
    strobe(); clear(); strobe();
    cfg_we = 1; cfg_src = 3'b000; cfg_phase = 2'b01; cfg_rate = 2'b10;
    smp_vld = 1; tick();
    chk("R7 strobe with write dropped", 32'(rdy_flag), 0);
    strobe();
    chk("R7 first strobe after write captured", 32'(rdy_flag), 1);
    clear();

    // R8 masked ready
    cfg(3'b000, 2'b00, 2'b00);
    rdy_mask = 0;
    strobe();
    chk("R8 flag set while masked", 32'(rdy_flag), 1);
    chk("R8 irq high while masked", 32'(irq_n), 1);
    rdy_mask = 1; #1;
    chk("R8 irq low after unmask", 32'(irq_n), 0);

    // R9 read colliding with capture
    stat_rd = 1; strobe();
    chk("R9 capture beats read", 32'(rdy_flag), 1);
    clear();
    chk("R9 read clears", 32'(rdy_flag), 0);
    chk("R9 irq released", 32'(irq_n), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) begin
        cfg_we = 1;
        cfg_src = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(2, 7)) : 3'($urandom_range(0, 1));
        cfg_phase = 2'($urandom);
        cfg_rate = 2'($urandom);
      end
      if ($urandom_range(0, 1) == 1) begin
        cur_bus = {$urandom, $urandom, $urandom};
        volt_bus = {$urandom, $urandom};
        smp_vld = 1;
      end
      stat_rd = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) rdy_mask = ~rdy_mask;
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule